// File: doc/BRIEF.md
# Lockstep Roll-Forward Recovery Controller

This block supervises a pair of processor cores that run in lockstep. While both cores agree, it does nothing. When the output comparator flags a disagreement, the controller runs a fixed recovery sequence:

- It asks an external scanner to find the upset, and the scanner names the faulty core.
- It asks a reconfiguration agent to repair that region.
- It interrupts both cores so that they enter their recovery routines.
- It asks for the architectural state of the healthy core to be copied into the repaired one.

After the copy, the pair runs in step again. No checkpoint is ever taken. The healthy core's current state is the recovery point, so the system moves forward and never rolls back.

A repair can leave an error behind in sequential logic. The agent reports this case with a residual flag. The controller then orders a second, whole-module repair pass and pulses an internal reset into the faulty core's module. Every phase that waits on an outside agent has a cycle budget. If the budget runs out, the controller parks in a fatal state until a global reset.

Top module: `lockstep_recovery_ctrl`

## Requirements
- R1: `phase_o` reports the phase with these codes: 0 normal, 1 mismatch seen, 2 scan, 3 repair, 4 completion, 5 interrupt, 6 resync, 7 fatal. During and right after reset, the phase is 0 and every request, interrupt, reset, pulse and fatal output is low.
- R2: The controller leaves normal operation only when `mismatch_i` is high. It then shows phase 1 for one cycle and moves to phase 2 in the following cycle.
- R3: In the scan phase, `scan_req_o` stays high until `scan_done_i`. No repair request is raised before that. The value of `scan_core_i` in the `scan_done_i` cycle is latched and shown on `faulty_core_o`.
- R4: In the repair phase, `reconf_req_o` stays high until `reconf_done_i`, with `reconf_whole_o` low on the first pass. One completion cycle follows, with every request low.
- R5: If `reconf_residual_i` is high with the done of the first pass, the controller runs a second repair pass with `reconf_whole_o` high. Its completion cycle pulses `core_rst_o` for one cycle on the bit of the faulty core (bit 0 or bit 1). The residual flag on a whole-module pass has no effect.
- R6: In the interrupt phase, both `irq_o` bits are high. They stay high until both cores have acknowledged, even if the acknowledges arrive in different cycles. Both bits then fall in the same cycle, the first cycle of resync.
- R7: In resync, `copy_req_o` stays high until `copy_done_i`. `copy_src_o` names the core that was not faulty.
- R8: After `copy_done_i`, the controller returns to phase 0, and `recovered_o` is high for exactly that first cycle.
- R9: While the phase is not 0, `mismatch_i` has no effect on the sequence or the outputs.
- R10: Each waiting phase (scan, repair, interrupt, resync) accepts its done within `TIMEOUT_CYC` cycles of entry, the last of those cycles included. Otherwise the controller enters phase 7 with `fatal_o` high and all requests and interrupts low. It holds there, whatever the inputs, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mismatch_i | input | 1 | Comparator disagreement flag |
| scan_req_o | output | 1 | Localization request to scanner |
| scan_done_i | input | 1 | Scanner finished |
| scan_core_i | input | 1 | Faulty core reported by scanner |
| reconf_req_o | output | 1 | Repair request to reconfiguration agent |
| reconf_whole_o | output | 1 | Repair covers the whole module |
| reconf_done_i | input | 1 | Repair pass finished |
| reconf_residual_i | input | 1 | Error persisted after the pass |
| core_rst_o | output | 2 | Per-core internal module reset pulse |
| irq_o | output | 2 | Recovery interrupt, one per core |
| irq_ack_i | input | 2 | Interrupt acknowledge, one per core |
| copy_req_o | output | 1 | State copy request |
| copy_src_o | output | 1 | Core supplying the state |
| copy_done_i | input | 1 | State copy finished |
| faulty_core_o | output | 1 | Latched faulty core |
| recovered_o | output | 1 | One-cycle resynchronized pulse |
| fatal_o | output | 1 | Timeout fatal state |
| phase_o | output | 3 | Current phase code |

## Verification
The assertions assume that every done input is a single-cycle pulse raised only while its request is high. They also assume that each acknowledge is raised only while the interrupt is high. The stimulus keeps to these rules: each agent is modelled as a bench task that pulses its done only after it has seen its own request. Random delays are drawn below the timeout budget, except in the directed timeout and last-cycle cases. Noise on `mismatch_i` is applied only in phases where it must be ignored, and it is cleared before the controller returns to normal.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    localparam int NUM_CORES = 2;

    typedef enum logic [2:0] {
        PH_NORMAL   = 3'd0,
        PH_DETECT   = 3'd1,
        PH_SCAN     = 3'd2,
        PH_REPAIR   = 3'd3,
        PH_COMPLETE = 3'd4,
        PH_INTR     = 3'd5,
        PH_RESYNC   = 3'd6,
        PH_FATAL    = 3'd7
    } phase_e;

    // Episode context carried from scan through resync.
    typedef struct packed {
        logic whole;     // repair pass covers the whole module
        logic residual;  // first pass left an error behind
        logic core;      // faulty core index
    } ctx_t;

    function automatic logic [NUM_CORES-1:0] core_onehot(input logic c);
        return c ? 2'b10 : 2'b01;
    endfunction

    function automatic logic waits_on_agent(input phase_e p);
        return (p == PH_SCAN) || (p == PH_REPAIR) || (p == PH_INTR) || (p == PH_RESYNC);
    endfunction

endpackage

// File: rtl/lsr_phase_timer.sv
module lsr_phase_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LAST);
endmodule

// File: rtl/lsr_irq_gather.sv
module lsr_irq_gather
    import lsr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 arm,
    input  logic [NUM_CORES-1:0] ack_i,
    output logic [NUM_CORES-1:0] irq_o,
    output logic                 all_acked
);
    logic [NUM_CORES-1:0] seen_q;
    logic [NUM_CORES-1:0] seen_now;

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        always_ff @(posedge clk) begin
            if (rst || !arm) begin
                seen_q[g] <= 1'b0;
            end else if (ack_i[g]) begin
                seen_q[g] <= 1'b1;
            end
        end
        assign seen_now[g] = seen_q[g] | ack_i[g];
        assign irq_o[g]    = arm;
    end

    assign all_acked = arm && (&seen_now);
endmodule

// File: rtl/lsr_sequencer.sv
module lsr_sequencer
    import lsr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   mismatch_i,
    input  logic   scan_done_i,
    input  logic   scan_core_i,
    input  logic   reconf_done_i,
    input  logic   reconf_residual_i,
    input  logic   all_acked_i,
    input  logic   copy_done_i,
    input  logic   expired_i,
    output phase_e phase_o,
    output logic   phase_chg_o,
    output ctx_t   ctx_o,
    output logic   recovered_o
);
    phase_e cur_q, nxt;
    ctx_t   ctx_q, ctx_n;
    logic   recovered_q;

    always_comb begin
        nxt   = cur_q;
        ctx_n = ctx_q;
        case (cur_q)
            PH_NORMAL: begin
                if (mismatch_i) nxt = PH_DETECT;
            end
            PH_DETECT: begin
                nxt   = PH_SCAN;
                ctx_n = '0;
            end
            PH_SCAN: begin
                if (scan_done_i) begin
                    nxt        = PH_REPAIR;
                    ctx_n.core = scan_core_i;
                end else if (expired_i) begin
                    nxt = PH_FATAL;
                end
            end
            PH_REPAIR: begin
                if (reconf_done_i) begin
                    nxt            = PH_COMPLETE;
                    ctx_n.residual = reconf_residual_i & ~ctx_q.whole;
                end else if (expired_i) begin
                    nxt = PH_FATAL;
                end
            end
            PH_COMPLETE: begin
                if (ctx_q.residual) begin
                    nxt            = PH_REPAIR;
                    ctx_n.whole    = 1'b1;
                    ctx_n.residual = 1'b0;
                end else begin
                    nxt = PH_INTR;
                end
            end
            PH_INTR: begin
                if (all_acked_i)    nxt = PH_RESYNC;
                else if (expired_i) nxt = PH_FATAL;
            end
            PH_RESYNC: begin
                if (copy_done_i)    nxt = PH_NORMAL;
                else if (expired_i) nxt = PH_FATAL;
            end
            default: nxt = PH_FATAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q       <= PH_NORMAL;
            ctx_q       <= '0;
            recovered_q <= 1'b0;
        end else begin
            cur_q       <= nxt;
            ctx_q       <= ctx_n;
            recovered_q <= (cur_q == PH_RESYNC) && copy_done_i;
        end
    end

    assign phase_o     = cur_q;
    assign phase_chg_o = (nxt != cur_q);
    assign ctx_o       = ctx_q;
    assign recovered_o = recovered_q;
endmodule

// File: rtl/lockstep_recovery_ctrl.sv
module lockstep_recovery_ctrl
    import lsr_pkg::*;
#(
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mismatch_i,
    output logic       scan_req_o,
    input  logic       scan_done_i,
    input  logic       scan_core_i,
    output logic       reconf_req_o,
    output logic       reconf_whole_o,
    input  logic       reconf_done_i,
    input  logic       reconf_residual_i,
    output logic [1:0] core_rst_o,
    output logic [1:0] irq_o,
    input  logic [1:0] irq_ack_i,
    output logic       copy_req_o,
    output logic       copy_src_o,
    input  logic       copy_done_i,
    output logic       faulty_core_o,
    output logic       recovered_o,
    output logic       fatal_o,
    output logic [2:0] phase_o
);
    phase_e phase;
    ctx_t   ctx;
    logic   phase_chg, expired, all_acked, recovered;

    lsr_sequencer u_seq (
        .clk               (clk),
        .rst               (rst),
        .mismatch_i        (mismatch_i),
        .scan_done_i       (scan_done_i),
        .scan_core_i       (scan_core_i),
        .reconf_done_i     (reconf_done_i),
        .reconf_residual_i (reconf_residual_i),
        .all_acked_i       (all_acked),
        .copy_done_i       (copy_done_i),
        .expired_i         (expired),
        .phase_o           (phase),
        .phase_chg_o       (phase_chg),
        .ctx_o             (ctx),
        .recovered_o       (recovered)
    );

    lsr_phase_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (phase_chg),
        .expired (expired)
    );

    lsr_irq_gather u_irq (
        .clk       (clk),
        .rst       (rst),
        .arm       (phase == PH_INTR),
        .ack_i     (irq_ack_i),
        .irq_o     (irq_o),
        .all_acked (all_acked)
    );

    assign scan_req_o     = (phase == PH_SCAN);
    assign reconf_req_o   = (phase == PH_REPAIR);
    assign reconf_whole_o = (phase == PH_REPAIR) && ctx.whole;
    assign core_rst_o     = ((phase == PH_COMPLETE) && ctx.whole) ? core_onehot(ctx.core) : 2'b00;
    assign copy_req_o     = (phase == PH_RESYNC);
    assign copy_src_o     = ~ctx.core;
    assign faulty_core_o  = ctx.core;
    assign recovered_o    = recovered;
    assign fatal_o        = (phase == PH_FATAL);
    assign phase_o        = phase;
endmodule

// File: rtl/lsr_ctrl_checker.sv
module lsr_ctrl_checker (
    input logic       clk,
    input logic       rst,
    input logic       mismatch_i,
    input logic       scan_req_o,
    input logic       scan_done_i,
    input logic       scan_core_i,
    input logic       reconf_req_o,
    input logic       reconf_whole_o,
    input logic       reconf_done_i,
    input logic       reconf_residual_i,
    input logic [1:0] core_rst_o,
    input logic [1:0] irq_o,
    input logic [1:0] irq_ack_i,
    input logic       copy_req_o,
    input logic       copy_src_o,
    input logic       copy_done_i,
    input logic       faulty_core_o,
    input logic       recovered_o,
    input logic       fatal_o,
    input logic [2:0] phase_o
);
    a_r2_stay_normal: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 3'd0 && !mismatch_i) |=> (phase_o == 3'd0));

    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        (phase_o != 3'd0) |=> (phase_o != 3'd1));

    a_r3_scan_first: assert property (@(posedge clk) disable iff (rst)
        (reconf_req_o && !$past(reconf_req_o) && !reconf_whole_o) |-> $past(scan_done_i));

    a_r4_one_request: assert property (@(posedge clk) disable iff (rst)
        $onehot0({scan_req_o, reconf_req_o, copy_req_o, irq_o[0]}));

    a_r5_rst_onehot: assert property (@(posedge clk) disable iff (rst)
        (|core_rst_o) |-> ($countones(core_rst_o) == 1));

    a_r5_rst_pulse: assert property (@(posedge clk) disable iff (rst)
        (|core_rst_o) |=> (core_rst_o == 2'b00));

    a_r6_irq_pair: assert property (@(posedge clk) disable iff (rst)
        irq_o[0] == irq_o[1]);

    a_r7_copy_after_irq: assert property (@(posedge clk) disable iff (rst)
        (copy_req_o && !$past(copy_req_o)) |-> ($past(irq_o) == 2'b11));

    a_r8_recovered_pulse: assert property (@(posedge clk) disable iff (rst)
        recovered_o |=> !recovered_o);

    a_r8_recovered_normal: assert property (@(posedge clk) disable iff (rst)
        recovered_o |-> (phase_o == 3'd0));

    a_r10_fatal_hold: assert property (@(posedge clk) disable iff (rst)
        fatal_o |=> (fatal_o && !scan_req_o && !reconf_req_o && !copy_req_o && irq_o == 2'b00));
endmodule

bind lockstep_recovery_ctrl lsr_ctrl_checker u_chk (.*);

// File: tb/tb_lockstep_recovery_ctrl.sv
module tb_lockstep_recovery_ctrl;
    localparam int TO = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mismatch_i = 0, scan_done_i = 0, scan_core_i = 0;
    logic reconf_done_i = 0, reconf_residual_i = 0, copy_done_i = 0;
    logic [1:0] irq_ack_i = 0;
    logic scan_req_o, reconf_req_o, reconf_whole_o, copy_req_o, copy_src_o;
    logic faulty_core_o, recovered_o, fatal_o;
    logic [1:0] core_rst_o, irq_o;
    logic [2:0] phase_o;

    int nvec = 0;
    int nfail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    lockstep_recovery_ctrl #(.TIMEOUT_CYC(TO)) dut (.*);

    task automatic check(input string req, input int act, input int exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        mismatch_i = 0; scan_done_i = 0; reconf_done_i = 0;
        reconf_residual_i = 0; copy_done_i = 0; irq_ack_i = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1 reset phase", phase_o, 0);
        check("R1 reset outputs",
              {scan_req_o, reconf_req_o, copy_req_o, irq_o, core_rst_o, recovered_o, fatal_o}, 0);
    endtask

    // Drive from normal into the scan phase (ends on first scan negedge).
    task automatic enter_scan(input bit noise);
        mismatch_i = 1'b1;
        @(negedge clk);
        check("R2 detect phase", phase_o, 1);
        mismatch_i = noise;
        @(negedge clk);
        check("R2 scan phase", phase_o, 2);
        check("R3 scan request", scan_req_o, 1);
        check("R3 no early repair", reconf_req_o, 0);
    endtask

    task automatic episode(input bit c, input bit resid, input int ls, input int lr,
                           input int la0, input int la1, input int lc, input bit noise,
                           input bit stall_irq);
        int m;
        enter_scan(noise);
        repeat (ls) begin
            @(negedge clk);
            check("R3 repair held off", reconf_req_o, 0);
        end
        check("R10 scan within budget", phase_o, 2);
        scan_core_i = c; scan_done_i = 1'b1;
        @(negedge clk);
        scan_done_i = 0; scan_core_i = ~c;
        check("R4 repair phase", phase_o, 3);
        check("R4 repair request", reconf_req_o, 1);
        check("R4 first pass partial", reconf_whole_o, 0);
        check("R3 faulty core latched", faulty_core_o, c);
        repeat (lr) @(negedge clk);
        reconf_done_i = 1'b1; reconf_residual_i = resid;
        @(negedge clk);
        reconf_done_i = 0; reconf_residual_i = 0;
        check("R4 completion phase", phase_o, 4);
        check("R4 completion no request", reconf_req_o, 0);
        check("R5 no reset on partial", core_rst_o, 0);
        if (resid) begin
            @(negedge clk);
            check("R5 whole pass phase", phase_o, 3);
            check("R5 whole pass flag", reconf_whole_o, 1);
            repeat (lr) @(negedge clk);
            reconf_done_i = 1'b1; reconf_residual_i = 1'b1;
            @(negedge clk);
            reconf_done_i = 0; reconf_residual_i = 0;
            check("R5 whole completion", phase_o, 4);
            check("R5 module reset pulse", core_rst_o, c ? 2 : 1);
        end
        @(negedge clk);
        check("R6 interrupt phase", phase_o, 5);
        check("R6 both interrupts", irq_o, 3);
        check("R5 reset pulse ended", core_rst_o, 0);
        if (stall_irq) begin
            for (int k = 0; k < TO; k++) begin
                irq_ack_i = (k == 0) ? 2'b01 : 2'b00;
                @(negedge clk);
                if (k < TO - 1) check("R6 held on single ack", irq_o, 3);
            end
            irq_ack_i = 0;
            check("R10 interrupt timeout fatal", phase_o, 7);
            check("R10 fatal flag", fatal_o, 1);
            check("R10 fatal irq low", irq_o, 0);
            return;
        end
        m = (la0 > la1) ? la0 : la1;
        for (int k = 0; k <= m; k++) begin
            irq_ack_i = {(k == la1), (k == la0)};
            @(negedge clk);
            if (k < m) check("R6 held until both ack", irq_o, 3);
        end
        irq_ack_i = 0;
        mismatch_i = 0;
        check("R7 resync phase", phase_o, 6);
        check("R6 interrupts drop together", irq_o, 0);
        check("R7 copy request", copy_req_o, 1);
        check("R7 copy source", copy_src_o, ~c & 1'b1);
        repeat (lc) @(negedge clk);
        copy_done_i = 1'b1;
        @(negedge clk);
        copy_done_i = 0;
        check("R8 back to normal", phase_o, 0);
        check("R8 recovered pulse", recovered_o, 1);
        @(negedge clk);
        check("R8 recovered single cycle", recovered_o, 0);
        check("R9 noise did not restart", phase_o, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R2: idle without mismatch stays normal
        repeat (5) @(negedge clk);
        check("R2 idle stays normal", phase_o, 0);

        // Directed corners
        episode(1'b0, 1'b0, 0, 0, 0, 0, 0, 1'b0, 1'b0);
        episode(1'b1, 1'b1, 3, 2, 4, 1, 2, 1'b1, 1'b0);
        episode(1'b1, 1'b0, TO - 1, TO - 1, TO - 1, 0, TO - 1, 1'b1, 1'b0); // R10 last cycle accepted

        // Random episodes
        for (int i = 0; i < 40; i++) begin
            episode(1'($urandom), 1'($urandom), int'($urandom % 12), int'($urandom % 12),
                    int'($urandom % 10), int'($urandom % 10), int'($urandom % 12),
                    1'($urandom), 1'b0);
            repeat (int'($urandom % 4)) @(negedge clk);
        end

        // R10: scan timeout
        enter_scan(1'b0);
        repeat (TO - 1) @(negedge clk);
        check("R10 scan last cycle", phase_o, 2);
        @(negedge clk);
        check("R10 scan timeout fatal", phase_o, 7);
        check("R10 fatal scan low", scan_req_o, 0);
        scan_done_i = 1; mismatch_i = 1; copy_done_i = 1;
        repeat (3) @(negedge clk);
        scan_done_i = 0; mismatch_i = 0; copy_done_i = 0;
        check("R10 fatal held", phase_o, 7);
        do_reset();

        // R10: interrupt timeout with only one acknowledge
        episode(1'b0, 1'b0, 1, 1, 0, 0, 0, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        check("R10 fatal held after irq", fatal_o, 1);
        do_reset();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule